// File: doc/BRIEF.md
# Watch Standby Controller

This controller places the device in a low-power watch standby state and brings it back out. Software first loads a two-bit mode selection register with the watch code and then writes a go bit to a command register. On the next clock edge the CPU clock, the internal system clock and the PLL clock are gated off. The oscillator and the clock feeding the watch timer and watchdog timer keep running. The controller is clocked by the free-running oscillator, and every clock-gate enable comes from a flop, so the enables change only on an oscillator edge.

Any non-maskable request, or any maskable request that is not masked, ends the standby at the next edge, whatever its priority. The controller then gives a one-cycle wake pulse to the interrupt controller. An acknowledge-enable flag travels with that pulse. It is set when the wake-up came from a non-maskable request, when no handler is in service, or when the request priority is strictly higher than the in-service level. A lower number means higher priority. Otherwise the request only wakes the device and stays pending.

While in standby, the external bus pins are held in a defined idle state. Because the oscillator never stopped, the CPU clock comes back with no stabilization wait.

Top module: `watch_ctl`

## Requirements
- R1: In standby, cpu_clk_en, sys_clk_en and pll_clk_en are 0. Outside standby they are 1. wt_clk_en and osc_en are 1 at all times.
- R2: A write with reg_sel=0 outside standby loads reg_wdata[1:0] into the mode register. A write with reg_sel=1 and reg_wdata[0]=1 sets in_watch at the next edge, but only if the mode register holds 2'b10. A command write with any other mode value has no effect, and so does any register write made while in standby.
- R3: In standby, nmi_req=1, or irq_req=1 with irq_mask=0, clears in_watch at the next edge for any irq_pri. A masked request (irq_mask=1) does not end standby.
- R4: A wake-up caused by an unmasked maskable request alone, while isr_active=1 and irq_pri >= isr_level, gives wake_pulse=1 with ack_en=0.
- R5: ack_en=1 together with wake_pulse when the wake-up has nmi_req=1, or has isr_active=0, or has irq_pri < isr_level.
- R6: wake_pulse is high for exactly the first cycle after release. ack_en is 0 whenever wake_pulse is 0.
- R7: In standby: pad_d_oe=0 and pad_a_oe=0; pad_rd_n, pad_wr_n and pad_cs_n are all ones; pad_clkout=0; cpu_wait_n=1 whatever pin_wait_n is. Outside standby, each of these follows its cpu_* or pin_* source.
- R8: cpu_clk_en returns to 1 in the same cycle that in_watch falls, with no stabilization delay.
- R9: rst_n=0 sampled at an edge clears in_watch, wake_pulse, ack_en and the mode register. Reset overrides a wake request present at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the mode register, 1 the command register |
| reg_wdata | input | 2 | Write data |
| nmi_req | input | 1 | Non-maskable interrupt request |
| irq_req | input | 1 | Maskable interrupt request |
| irq_mask | input | 1 | Mask bit of the maskable request |
| irq_pri | input | PW | Priority of the maskable request (0 highest) |
| isr_active | input | 1 | A handler is in service |
| isr_level | input | PW | Priority level in service |
| cpu_d_oe | input | 1 | CPU data bus drive enable |
| cpu_a_oe | input | 1 | CPU address bus drive enable |
| cpu_rd_n | input | 1 | CPU read strobe |
| cpu_wr_n | input | 2 | CPU byte write strobes |
| cpu_cs_n | input | CSW | CPU chip selects |
| cpu_clkout | input | 1 | Clock output source |
| pin_wait_n | input | 1 | External wait pin |
| in_watch | output | 1 | Standby active |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| sys_clk_en | output | 1 | Internal system clock gate enable |
| pll_clk_en | output | 1 | PLL clock gate enable |
| wt_clk_en | output | 1 | Watch and watchdog timer clock enable |
| osc_en | output | 1 | Oscillator run enable |
| wake_pulse | output | 1 | One-cycle release pulse |
| ack_en | output | 1 | Acknowledge permitted with this release |
| pad_d_oe | output | 1 | Data pad drive enable |
| pad_a_oe | output | 1 | Address pad drive enable |
| pad_rd_n | output | 1 | Read strobe pad |
| pad_wr_n | output | 2 | Write strobe pads |
| pad_cs_n | output | CSW | Chip-select pads |
| pad_clkout | output | 1 | Clock output pad |
| cpu_wait_n | output | 1 | Wait seen by the CPU |

## Verification
The mode register, in_watch, the clock enables, wake_pulse and ack_en are all registered. Each of them is due exactly one rising edge after the write or request that causes it. The pad outputs and cpu_wait_n are combinational from in_watch and the current pin inputs, so they are due in the same cycle. The bench changes its inputs at a falling edge and applies them to a reference model at the following rising edge. It then compares every output at the next falling edge, so each sample lands half a period after the edge that produced it.

// File: rtl/watch_ctl.sv
module watch_ctl #(
  parameter int PW = 3,
  parameter int CSW = 4,
  parameter logic [1:0] WATCH_CODE = 2'b10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic           reg_sel,
  input  logic [1:0]     reg_wdata,
  input  logic           nmi_req,
  input  logic           irq_req,
  input  logic           irq_mask,
  input  logic [PW-1:0]  irq_pri,
  input  logic           isr_active,
  input  logic [PW-1:0]  isr_level,
  input  logic           cpu_d_oe,
  input  logic           cpu_a_oe,
  input  logic           cpu_rd_n,
  input  logic [1:0]     cpu_wr_n,
  input  logic [CSW-1:0] cpu_cs_n,
  input  logic           cpu_clkout,
  input  logic           pin_wait_n,
  output logic           in_watch,
  output logic           cpu_clk_en,
  output logic           sys_clk_en,
  output logic           pll_clk_en,
  output logic           wt_clk_en,
  output logic           osc_en,
  output logic           wake_pulse,
  output logic           ack_en,
  output logic           pad_d_oe,
  output logic           pad_a_oe,
  output logic           pad_rd_n,
  output logic [1:0]     pad_wr_n,
  output logic [CSW-1:0] pad_cs_n,
  output logic           pad_clkout,
  output logic           cpu_wait_n
);

  logic [1:0] mode_q;
  logic       run_q;

  wire go       = reg_wr && reg_sel && reg_wdata[0] && (mode_q == WATCH_CODE) && !in_watch;
  wire irq_live = irq_req && !irq_mask;
  wire wake     = in_watch && (nmi_req || irq_live);
  wire urgent   = nmi_req || !isr_active || (irq_pri < isr_level);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q     <= 2'b00;
      in_watch   <= 1'b0;
      run_q      <= 1'b1;
      wake_pulse <= 1'b0;
      ack_en     <= 1'b0;
    end else begin
      if (reg_wr && !reg_sel && !in_watch)
        mode_q <= reg_wdata;
      if (go)
        in_watch <= 1'b1;
      else if (wake)
        in_watch <= 1'b0;
      run_q      <= !(go || (in_watch && !wake));
      wake_pulse <= wake;
      ack_en     <= wake && urgent;
    end
  end

  assign cpu_clk_en = run_q;
  assign sys_clk_en = run_q;
  assign pll_clk_en = run_q;
  assign wt_clk_en  = 1'b1;
  assign osc_en     = 1'b1;

  assign pad_d_oe   = in_watch ? 1'b0 : cpu_d_oe;
  assign pad_a_oe   = in_watch ? 1'b0 : cpu_a_oe;
  assign pad_rd_n   = in_watch ? 1'b1 : cpu_rd_n;
  assign pad_wr_n   = in_watch ? 2'b11 : cpu_wr_n;
  assign pad_cs_n   = in_watch ? {CSW{1'b1}} : cpu_cs_n;
  assign pad_clkout = in_watch ? 1'b0 : cpu_clkout;
  assign cpu_wait_n = in_watch ? 1'b1 : pin_wait_n;

endmodule

// File: rtl/watch_ctl_chk.sv
module watch_ctl_chk #(
  parameter int PW = 3,
  parameter logic [1:0] WATCH_CODE = 2'b10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic          reg_sel,
  input logic [1:0]    reg_wdata,
  input logic          nmi_req,
  input logic          irq_req,
  input logic          irq_mask,
  input logic [PW-1:0] irq_pri,
  input logic          isr_active,
  input logic [PW-1:0] isr_level,
  input logic [1:0]    mode_q,
  input logic          in_watch,
  input logic          cpu_clk_en,
  input logic          sys_clk_en,
  input logic          pll_clk_en,
  input logic          wake_pulse,
  input logic          ack_en,
  input logic          pad_d_oe,
  input logic          pad_a_oe,
  input logic          pad_rd_n,
  input logic          pad_clkout,
  input logic          cpu_wait_n
);

  assert_gates_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_watch |-> (!cpu_clk_en && !sys_clk_en && !pll_clk_en));

  assert_mode_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_sel && !in_watch) |=> (mode_q == $past(reg_wdata)));

  assert_enter_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel && reg_wdata[0] && mode_q == WATCH_CODE && !in_watch) |=> in_watch);

  assert_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_watch && (nmi_req || (irq_req && !irq_mask))) |=> (!in_watch && wake_pulse));

  assert_low_pri_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_watch && !nmi_req && irq_req && !irq_mask && isr_active && irq_pri >= isr_level)
      |=> (wake_pulse && !ack_en));

  assert_nmi_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_watch && nmi_req) |=> ack_en);

  assert_one_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse);

  assert_ack_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_en |-> wake_pulse);

  assert_idle_pins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_watch |-> (!pad_d_oe && !pad_a_oe && pad_rd_n && !pad_clkout && cpu_wait_n));

  assert_fast_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_watch) |-> cpu_clk_en);

  assert_reset_R9: assert property (@(posedge clk)
    !rst_n |=> (!in_watch && !wake_pulse && !ack_en && mode_q == 2'b00));

endmodule

bind watch_ctl watch_ctl_chk #(.PW(PW), .WATCH_CODE(WATCH_CODE)) u_chk (.*);

// File: tb/watch_ctl_tb.sv
module watch_ctl_tb;
  localparam int PW = 3;
  localparam int CSW = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, reg_wr, reg_sel, nmi_req, irq_req, irq_mask, isr_active;
  logic [1:0] reg_wdata;
  logic [PW-1:0] irq_pri, isr_level;
  logic cpu_d_oe, cpu_a_oe, cpu_rd_n, cpu_clkout, pin_wait_n;
  logic [1:0] cpu_wr_n;
  logic [CSW-1:0] cpu_cs_n;
  logic in_watch, cpu_clk_en, sys_clk_en, pll_clk_en, wt_clk_en, osc_en;
  logic wake_pulse, ack_en, pad_d_oe, pad_a_oe, pad_rd_n, pad_clkout, cpu_wait_n;
  logic [1:0] pad_wr_n;
  logic [CSW-1:0] pad_cs_n;

  watch_ctl #(.PW(PW), .CSW(CSW)) u_dut (.*);

  int checks = 0;
  int errors = 0;
  logic [1:0] m_mode;
  logic m_watch, m_wake, m_ack;

  function automatic logic want_ack(logic nmi, logic act, logic [PW-1:0] lvl, logic [PW-1:0] pri);
    return nmi || !act || (pri < lvl);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    reg_wr = 0; reg_sel = 0; reg_wdata = 0; nmi_req = 0; irq_req = 0; irq_mask = 0;
    irq_pri = 0; isr_active = 0; isr_level = 0;
  endtask

  task automatic model();
    logic rel, ent;
    if (!rst_n) begin
      m_mode = 0; m_watch = 0; m_wake = 0; m_ack = 0;
    end else begin
      rel = m_watch && (nmi_req || (irq_req && !irq_mask));
      ent = !m_watch && reg_wr && reg_sel && reg_wdata[0] && m_mode == 2'b10;
      m_ack = rel && want_ack(nmi_req, isr_active, isr_level, irq_pri);
      if (!m_watch && reg_wr && !reg_sel) m_mode = reg_wdata;
      m_wake = rel;
      m_watch = ent ? 1'b1 : (rel ? 1'b0 : m_watch);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1 model();
    @(negedge clk);
    chk("R2/R3 in_watch", in_watch, m_watch);
    chk("R1/R8 cpu_clk_en", cpu_clk_en, !m_watch);
    chk("R1 sys_clk_en", sys_clk_en, !m_watch);
    chk("R1 pll_clk_en", pll_clk_en, !m_watch);
    chk("R1 timer/osc enables", {wt_clk_en, osc_en}, 2'b11);
    chk("R6 wake_pulse", wake_pulse, m_wake);
    chk("R4/R5 ack_en", ack_en, m_ack);
    chk("R7 pad_d_oe", pad_d_oe, m_watch ? 1'b0 : cpu_d_oe);
    chk("R7 pad_a_oe", pad_a_oe, m_watch ? 1'b0 : cpu_a_oe);
    chk("R7 strobes", {pad_rd_n, pad_wr_n, pad_cs_n},
        m_watch ? {(3+CSW){1'b1}} : {cpu_rd_n, cpu_wr_n, cpu_cs_n});
    chk("R7 pad_clkout", pad_clkout, m_watch ? 1'b0 : cpu_clkout);
    chk("R7 cpu_wait_n", cpu_wait_n, m_watch ? 1'b1 : pin_wait_n);
  endtask

  task automatic wr(input logic sel, input logic [1:0] d);
    reg_wr = 1; reg_sel = sel; reg_wdata = d;
    tick();
    reg_wr = 0;
  endtask

  task automatic enter();
    wr(1'b0, 2'b10);
    wr(1'b1, 2'b01);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    idle();
    cpu_d_oe = 1; cpu_a_oe = 1; cpu_rd_n = 0; cpu_wr_n = 2'b00; cpu_cs_n = 0;
    cpu_clkout = 1; pin_wait_n = 0;
    rst_n = 0;
    @(negedge clk);
    tick();
    chk("R9 reset state", {in_watch, wake_pulse, ack_en, cpu_clk_en}, 4'b0001);
    rst_n = 1;

    wr(1'b1, 2'b01);
    chk("R9 mode cleared, command alone ignored", in_watch, 0);
    wr(1'b0, 2'b01);
    wr(1'b1, 2'b01);
    chk("R2 wrong mode code ignored", in_watch, 0);
    enter();
    chk("R2 entry", in_watch, 1);
    chk("R7 wait ignored in standby", cpu_wait_n, 1);
    irq_req = 1; irq_mask = 1; tick();
    chk("R3 masked request ignored", in_watch, 1);
    irq_mask = 0; isr_active = 1; isr_level = 3'd4; irq_pri = 3'd4; tick();
    chk("R4 equal priority wakes without ack", {wake_pulse, ack_en}, 2'b10);
    chk("R8 clock back at release", cpu_clk_en, 1);
    idle(); tick();
    chk("R6 pulse lasts one cycle", wake_pulse, 0);
    enter();
    irq_req = 1; isr_active = 1; isr_level = 3'd4; irq_pri = 3'd2; tick();
    chk("R5 higher priority acknowledged", {wake_pulse, ack_en}, 2'b11);
    idle(); enter();
    nmi_req = 1; isr_active = 1; isr_level = 3'd0; tick();
    chk("R5 nmi acknowledged", ack_en, 1);
    idle(); enter();
    wr(1'b0, 2'b00);
    chk("R2 write in standby ignored", in_watch, 1);
    nmi_req = 1; rst_n = 0; tick();
    chk("R9 reset beats wake", {in_watch, wake_pulse, ack_en}, 3'b000);
    idle(); rst_n = 1;

    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      idle();
      rst_n = (r != 0);
      if (r < 15) begin
        reg_wr = 1; reg_sel = 0;
        reg_wdata = ($urandom_range(0, 3) == 0) ? 2'($urandom) : 2'b10;
      end else if (r < 30) begin
        reg_wr = 1; reg_sel = 1; reg_wdata = 2'($urandom);
      end
      nmi_req = ($urandom_range(0, 39) == 0);
      irq_req = ($urandom_range(0, 7) == 0);
      irq_mask = ($urandom_range(0, 2) == 0);
      irq_pri = PW'($urandom);
      isr_active = $urandom_range(0, 1) != 0;
      isr_level = PW'($urandom);
      cpu_d_oe = 1'($urandom); cpu_a_oe = 1'($urandom); cpu_rd_n = 1'($urandom);
      cpu_wr_n = 2'($urandom); cpu_cs_n = CSW'($urandom);
      cpu_clkout = 1'($urandom); pin_wait_n = 1'($urandom);
      tick();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule